// File: doc/BRIEF.md
# Inverse Lapped-Transform Spectrum Builder

This block sits in front of an inverse FFT in an audio path that rebuilds time samples from M complex lapped-transform coefficients. Coefficients arrive one per accepted cycle in ascending index order. From each adjacent pair the block forms one lower-half bin, multiplied by a conjugated modulation factor from a constant table. In the same cycle it writes the conjugate of that bin to the mirrored address in the upper half. It forms the DC and Nyquist bins as purely real values. All 2M bins go into an internal RAM, which the inverse FFT reads through a registered read port.

A frame starts with the first accepted coefficient. After the last one, a single-cycle completion pulse says the spectrum is whole. The block then keeps the spectrum still: it ignores new coefficients until the consumer frees the frame, and after that the next frame may start.

Top module: `imclt_prefill`

## Requirements
- R1: After reset, `busy` and `done` are low.
- R2: For a coefficient at index k, 1 ≤ k ≤ M-1, with D = X(k-1) - j·X(k), the bin at address k is (Ar·Dre - Ai·Dim) >>> 17 for the real part and (Ar·Dim + Ai·Dre) >>> 17 for the imaginary part. Here >>> is a floor shift, and Ar, Ai are round-half-away(32768·cos θ) and round-half-away(32768·sin θ), saturated to [-32768, 32767], with θ = π(2k+1)/4 + πk/(2M).
- R3: For 1 ≤ k ≤ M-1, the bin at address 2M-k holds the real part of bin k and the negated imaginary part of bin k.
- R4: Bin 0 has real part ((Re X(0) + Im X(0))·11585) >>> 15 and imaginary part 0.
- R5: Bin M has real part -(((Re X(M-1) + Im X(M-1))·11585) >>> 15) and imaginary part 0.
- R6: `done` is high for exactly one cycle: the second cycle after the clock edge that accepts coefficient M-1.
- R7: `busy` rises in the cycle after the first coefficient of a frame is accepted. It stays high until the cycle in which `done` is high, where it is low.
- R8: From the completion pulse until `frame_free` is sampled high, `in_valid` has no effect: bins keep their values and `busy` stays low.
- R9: `rd_re`/`rd_im` show the bin addressed by `rd_addr` at the preceding clock edge, so the read latency is one cycle.
- R10: Cycles with `in_valid` low inside a frame do not advance the coefficient index and do not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficient strobe |
| in_re | input | 24 | Coefficient real part, signed |
| in_im | input | 24 | Coefficient imaginary part, signed |
| frame_free | input | 1 | Consumer has finished reading; allows a new frame |
| busy | output | 1 | Frame is being loaded |
| done | output | 1 | One-cycle pulse: spectrum complete |
| rd_addr | input | 8 | Bin address for the read port |
| rd_re | output | 26 | Registered bin real part |
| rd_im | output | 26 | Registered bin imaginary part |

## Verification
Bins 0 and 1..M-1, and their mirrors, are written at the edge that accepts their coefficient. Bin M is written one edge later, in the same cycle in which `done` is registered. So the bench samples `busy` and `done` at the falling edge one and two cycles after the last accepted coefficient, and the third falling edge confirms the pulse has ended. Every readout sets the address at a falling edge and samples one rising edge later. Expected bins come from integer arithmetic on the stimulus, over full frames with ramp, extreme, random and gapped inputs.

// File: rtl/imclt_prefill.sv
module imclt_prefill #(
  parameter int M  = 128,
  parameter int DW = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic signed [DW-1:0]         in_re,
  input  logic signed [DW-1:0]         in_im,
  input  logic                         frame_free,
  output logic                         busy,
  output logic                         done,
  input  logic [$clog2(2*M)-1:0]       rd_addr,
  output logic signed [DW+1:0]         rd_re,
  output logic signed [DW+1:0]         rd_im
);
  localparam int AW = $clog2(2*M);
  localparam int KW = $clog2(M);
  localparam int OW = DW + 2;
  localparam int PW = DW + 18;
  localparam int QW = DW + 17;
  localparam real PI = 3.14159265358979323846;
  localparam logic signed [15:0] ISQ8 = 16'sd11585;
  localparam logic [AW:0] TWO_M = (AW+1)'(2*M);
  localparam logic [AW-1:0] MID = AW'(M);

  function automatic logic signed [15:0] q15(input real v);
    real s;
    int r;
    s = v * 32768.0;
    r = (s >= 0.0) ? $rtoi(s + 0.5) : $rtoi(s - 0.5);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return 16'(r);
  endfunction

  logic signed [15:0] cr_rom [M];
  logic signed [15:0] ci_rom [M];
  for (genvar g = 0; g < M; g++) begin : g_rom
    localparam real TH = PI * (2.0 * g + 1.0) / 4.0 + PI * g / (2.0 * M);
    localparam logic signed [15:0] CR = q15($cos(TH));
    localparam logic signed [15:0] CI = q15($sin(TH));
    assign cr_rom[g] = CR;
    assign ci_rom[g] = CI;
  end

  logic signed [OW-1:0] mem_re [2*M];
  logic signed [OW-1:0] mem_im [2*M];

  logic [KW-1:0] idx;
  logic fin, full;
  logic signed [DW-1:0] prev_re, prev_im;

  wire take = in_valid && !full && !fin;

  logic signed [DW:0] d_re, d_im, s0, sm;
  assign d_re = DW'(prev_re) + in_im;
  assign d_im = DW'(prev_im) - in_re;
  assign s0 = (DW+1)'(in_re) + (DW+1)'(in_im);
  assign sm = (DW+1)'(prev_re) + (DW+1)'(prev_im);

  logic signed [15:0] cr, ci;
  assign cr = cr_rom[idx];
  assign ci = ci_rom[idx];

  logic signed [PW-1:0] p_re, p_im;
  assign p_re = PW'(d_re) * PW'(cr) - PW'(d_im) * PW'(ci);
  assign p_im = PW'(d_im) * PW'(cr) + PW'(d_re) * PW'(ci);

  logic signed [OW-1:0] lo_re, lo_im;
  assign lo_re = OW'(p_re >>> 17);
  assign lo_im = OW'(p_im >>> 17);

  logic signed [QW-1:0] q0, qm;
  assign q0 = QW'(s0) * QW'(ISQ8);
  assign qm = QW'(sm) * QW'(ISQ8);

  logic signed [OW-1:0] y0, tm, ym;
  assign y0 = OW'(q0 >>> 15);
  assign tm = OW'(qm >>> 15);
  assign ym = -tm;

  logic [AW-1:0] wa, wb;
  assign wa = AW'(idx);
  assign wb = AW'(TWO_M - (AW+1)'(idx));

  always_ff @(posedge clk) begin
    if (take) begin
      if (idx == '0) begin
        mem_re[0] <= y0;
        mem_im[0] <= '0;
      end else begin
        mem_re[wa] <= lo_re;
        mem_im[wa] <= lo_im;
        mem_re[wb] <= lo_re;
        mem_im[wb] <= -lo_im;
      end
    end
    if (fin) begin
      mem_re[MID] <= ym;
      mem_im[MID] <= '0;
    end
    rd_re <= mem_re[rd_addr];
    rd_im <= mem_im[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      fin <= 1'b0;
      full <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      prev_re <= '0;
      prev_im <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        prev_re <= in_re;
        prev_im <= in_im;
        busy <= 1'b1;
        if (idx == KW'(M-1)) begin
          idx <= '0;
          fin <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (fin) begin
        fin <= 1'b0;
        full <= 1'b1;
        done <= 1'b1;
        busy <= 1'b0;
      end
      if (full && frame_free) full <= 1'b0;
    end
  end
endmodule

// File: rtl/imclt_prefill_chk.sv
module imclt_prefill_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R6
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R7
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R7
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
endmodule

bind imclt_prefill imclt_prefill_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done)
);

// File: tb/sim_imclt_prefill.sv
`timescale 1ns/1ps
module sim_imclt_prefill;
  localparam int M = 128;
  localparam int DW = 24;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic frame_free = 1'b0;
  logic busy, done;
  logic [7:0] rd_addr = '0;
  logic signed [DW+1:0] rd_re, rd_im;

  int checks = 0;
  int errors = 0;

  longint xr [M];
  longint xi [M];
  longint er [2*M];
  longint ei [2*M];

  always #2.5 clk = ~clk;

  imclt_prefill #(.M(M), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .frame_free(frame_free), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im)
  );

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint qf(input real v);
    real s;
    longint r;
    s = v * 32768.0;
    r = (s >= 0.0) ? longint'($rtoi(s + 0.5)) : longint'($rtoi(s - 0.5));
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic build_expected();
    longint ar, ai, dre, dim, pre, pim;
    real th;
    er[0] = ((xr[0] + xi[0]) * 11585) >>> 15;
    ei[0] = 0;
    er[M] = -(((xr[M-1] + xi[M-1]) * 11585) >>> 15);
    ei[M] = 0;
    for (int k = 1; k < M; k++) begin
      th = PI * (2.0 * k + 1.0) / 4.0 + PI * k / (2.0 * M);
      ar = qf($cos(th));
      ai = qf($sin(th));
      dre = xr[k-1] + xi[k];
      dim = xi[k-1] - xr[k];
      pre = ar * dre - ai * dim;
      pim = ar * dim + ai * dre;
      er[k] = pre >>> 17;
      ei[k] = pim >>> 17;
      er[2*M-k] = pre >>> 17;
      ei[2*M-k] = -(pim >>> 17);
    end
  endtask

  task automatic make_pattern(input int p);
    for (int k = 0; k < M; k++) begin
      case (p)
        0: begin xr[k] = longint'(k) * 65521 - 4194304; xi[k] = 3000000 - longint'(k) * 47111; end
        1: begin
             xr[k] = (k % 2 == 0) ? 8388607 : -8388608;
             xi[k] = (k % 3 == 0) ? -8388608 : 8388607;
           end
        2: begin
             xr[k] = longint'($signed(24'($urandom)));
             xi[k] = longint'($signed(24'($urandom)));
           end
        default: begin xr[k] = longint'(k % 7) - 3; xi[k] = longint'(k % 5) * 2 - 4; end
      endcase
    end
  endtask

  task automatic run_frame(input int p, input bit gaps);
    int e0;
    make_pattern(p);
    build_expected();
    e0 = errors;
    for (int k = 0; k < M; k++) begin
      @(negedge clk);
      if (k == 1) chk("R7", longint'(busy), 1, "busy after first input");
      if (gaps && (k % 4 == 2)) begin
        in_valid = 1'b0;
        in_re = 24'sh5A5A5A;
        in_im = -24'sd77;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_re = DW'(xr[k]);
      in_im = DW'(xi[k]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", longint'(busy), 1, "busy one cycle after last input");
    chk("R6", longint'(done), 0, "done one cycle after last input");
    @(negedge clk);
    chk("R6", longint'(done), 1, "done two cycles after last input");
    chk("R7", longint'(busy), 0, "busy during done");
    // R8: stimulus while holding must be ignored
    in_valid = 1'b1;
    for (int g = 0; g < 6; g++) begin
      in_re = DW'(g * 1234567);
      in_im = DW'(-g * 7654321);
      @(negedge clk);
      if (g == 0) chk("R6", longint'(done), 0, "done after pulse");
      chk("R8", longint'(busy), 0, "busy while holding");
    end
    in_valid = 1'b0;
    rd_addr = 8'd0;
    for (int a = 0; a < 2*M; a++) begin
      @(negedge clk);
      if (a == 0)           begin chk("R4", longint'(rd_re), er[a], "bin0 re"); chk("R4", longint'(rd_im), 0, "bin0 im"); end
      else if (a == M)      begin chk("R5", longint'(rd_re), er[a], "binM re"); chk("R5", longint'(rd_im), 0, "binM im"); end
      else if (a < M)       begin chk("R2", longint'(rd_re), er[a], "low re"); chk("R2", longint'(rd_im), ei[a], "low im"); end
      else                  begin chk("R3", longint'(rd_re), er[a], "mirror re"); chk("R3", longint'(rd_im), ei[a], "mirror im"); end
      if (a + 1 < 2*M) rd_addr = 8'(a + 1);
    end
    // R9: one-cycle read latency, back-to-back addresses
    rd_addr = 8'd3;
    @(negedge clk);
    rd_addr = 8'(M);
    chk("R9", longint'(rd_re), er[3], "read latency first");
    @(negedge clk);
    chk("R9", longint'(rd_re), er[M], "read latency second");
    chk("R8", longint'(errors - e0), 0, "readout after ignored inputs");
    if (gaps) chk("R10", longint'(errors - e0), 0, "gapped frame results");
    frame_free = 1'b1;
    @(negedge clk);
    frame_free = 1'b0;
    chk("R8", longint'(busy), 0, "busy after release");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", longint'(busy), 0, "busy in reset");
    chk("R1", longint'(done), 0, "done in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", longint'(busy), 0, "busy after reset");
    chk("R1", longint'(done), 0, "done after reset");
    run_frame(0, 1'b0);
    run_frame(1, 1'b0);
    run_frame(2, 1'b0);
    run_frame(3, 1'b1);
    run_frame(2, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule